// File: doc/BRIEF.md
# Hardware Queue Slot Mapping Scheduler

This block shares a small pool of hardware queue slots among a larger population of software-created queues. For every possible queue it holds an active bit, a mapped bit, a slot number and a 16-bit write index. For every slot it holds an occupied bit and the index of the queue that occupies it. Two round-robin pointers drive every search: one walks the queue space and one walks the slot pool. Each search completes in a single cycle through a rotated priority encoder.

Commands enter on a valid/ready interface, at most one per cycle. There are three kinds. Create adds a queue and places it at once if a slot is free. Destroy removes a queue; if it occupied a slot, the freed slot is refilled in the same cycle. Doorbell is addressed by byte offset: it updates a queue's write index and asks the fetch engine to fetch when the queue holds a slot. When fewer queues are mapped than are active, a wakeup timer is armed. When it expires, the block brings the next unmapped queue into a free slot. If no slot is free, it evicts an idle occupant, where idle means no DMA in flight and no outstanding packets. The block stalls commands for that one cycle.

Top module: `qslot_sched`

## Requirements
- R1: After reset no queue is active or mapped, no slot is occupied, both pointers are 0, no pulse output is high, `wake_pending_o` is 0 and `cmd_ready` is 1.
- R2: A create (op 0) is rejected if its queue index is at or above NQ or the queue is already active. A rejected create pulses `err_o` for one cycle and leaves all queue and slot state unchanged.
- R3: An accepted create marks the queue active with write index 0. If any slot is free, the queue is mapped into the first free slot found from the slot pointer with wraparound. After any mapping, the queue pointer becomes (queue+1) mod NQ and the slot pointer becomes (slot+1) mod NS.
- R4: A create that finds no free slot leaves the queue active but unmapped.
- R5: A wakeup is armed only when none is pending and the count of mapped queues is below the count of active queues. It loads `wake_delay` and fires exactly `wake_delay`+1 cycles after the arming edge. In the firing cycle `cmd_ready` is 0.
- R6: When a wakeup fires, the block picks the first active, unmapped queue from the queue pointer with wraparound. It maps that queue into a free slot if one exists. Otherwise it evicts the occupant of the first slot, scanning from the slot pointer, whose `slot_dma_busy` and `slot_pkts_busy` bits are both 0.
- R7: If a wakeup finds neither a free slot nor an idle slot, nothing changes.
- R8: A doorbell (op 2) decodes `cmd_addr` as queue index times 4. It is an error if the address is not a multiple of 4, the index is at or above NQ, or the queue is not active. Otherwise it stores `cmd_data` as the write index and, if the queue is mapped, pulses `fetch_req_o` on its slot only.
- R9: A destroy (op 1) of an inactive or out-of-range queue is an error. Otherwise the queue is removed, and `warn_o` pulses if `cmd_rdidx` differs from its stored write index. If the queue was mapped, its slot is freed and refilled in the same cycle by the next unmapped active queue.
- R10: Whenever a queue is mapped into slot s and `slot_disp_pend[s]` is 1, bit s of `fetch_req_o` and of `sched_req_o` pulse for one cycle.
- R11: Op 3 is reserved: it pulses `err_o` and changes nothing.
- R12: Pulse outputs last one cycle after the event, and `fetch_req_o` has at most one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted this cycle when high with valid |
| cmd_op | input | 2 | 0 create, 1 destroy, 2 doorbell, 3 reserved |
| cmd_qid | input | QW (4) | Queue index for create and destroy |
| cmd_addr | input | QW+2 (6) | Doorbell byte offset |
| cmd_data | input | WW (16) | Doorbell write index |
| cmd_rdidx | input | WW (16) | Read index of the queue being destroyed |
| wake_delay | input | DW (16) | Wakeup delay in cycles |
| slot_dma_busy | input | NS (4) | Per-slot DMA in progress |
| slot_pkts_busy | input | NS (4) | Per-slot in-flight packets nonzero |
| slot_disp_pend | input | NS (4) | Per-slot dispatch pending |
| slot_valid_o | output | NS (4) | Slot occupied |
| slot_qid_o | output | NS*QIW (12) | Occupant queue index per slot |
| q_valid_o | output | NQ (8) | Queue active |
| q_mapped_o | output | NQ (8) | Queue holds a slot |
| fetch_req_o | output | NS (4) | One-cycle fetch request per slot |
| sched_req_o | output | NS (4) | One-cycle schedule request per slot |
| err_o | output | 1 | One-cycle command error |
| warn_o | output | 1 | One-cycle non-empty destroy warning |
| wake_pending_o | output | 1 | Wakeup timer running |

## Verification
The checks assume that the busy and dispatch-pending flags change only between cycles and do not depend on this cycle's command. They also assume that commands and wakeups never share a cycle, which `cmd_ready` enforces. From those two premises, occupancy, one-hot pulses and unchanged state after an error hold as invariants. The stimulus changes slot flags only just after a rising edge and offers commands only while `cmd_ready` is high. A reference model applies each wakeup when it observes `cmd_ready` low, sweeps every doorbell offset and every out-of-range queue index, and walks eviction through both busy inputs.

// File: rtl/qs_pkg.sv
package qs_pkg;
    typedef enum logic [1:0] {
        OP_CREATE   = 2'd0,
        OP_DESTROY  = 2'd1,
        OP_DOORBELL = 2'd2,
        OP_RSVD     = 2'd3
    } qs_op_e;
endpackage

// File: rtl/qs_rr_pick.sv
module qs_rr_pick #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] base,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        int j;
        found = 1'b0;
        idx   = '0;
        j     = 0;
        for (int i = 0; i < N; i++) begin
            j = (int'(base) + i) % N;
            if (!found && req[j]) begin
                found = 1'b1;
                idx   = IW'(j);
            end
        end
    end
endmodule

// File: rtl/qs_wake_timer.sv
module qs_wake_timer #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic [DW-1:0] delay,
    output logic          fire,
    output logic          pending
);
    typedef struct packed {
        logic          pend;
        logic [DW-1:0] cnt;
    } tmr_t;

    tmr_t t_q, t_d;

    assign fire    = t_q.pend && (t_q.cnt == '0);
    assign pending = t_q.pend;

    always_comb begin
        t_d = t_q;
        if (arm && (!t_q.pend || fire)) begin
            t_d.pend = 1'b1;
            t_d.cnt  = delay;
        end else if (fire) begin
            t_d.pend = 1'b0;
        end else if (t_q.pend) begin
            t_d.cnt = t_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end
endmodule

// File: rtl/qslot_sched.sv
module qslot_sched
    import qs_pkg::*;
#(
    parameter int NQ  = 8,
    parameter int NS  = 4,
    parameter int WW  = 16,
    parameter int DW  = 16,
    localparam int QIW = $clog2(NQ),
    localparam int QW  = QIW + 1,
    localparam int AW  = QW + 2,
    localparam int SW  = (NS > 1) ? $clog2(NS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic [QW-1:0]     cmd_qid,
    input  logic [AW-1:0]     cmd_addr,
    input  logic [WW-1:0]     cmd_data,
    input  logic [WW-1:0]     cmd_rdidx,
    input  logic [DW-1:0]     wake_delay,
    input  logic [NS-1:0]     slot_dma_busy,
    input  logic [NS-1:0]     slot_pkts_busy,
    input  logic [NS-1:0]     slot_disp_pend,
    output logic [NS-1:0]     slot_valid_o,
    output logic [NS*QIW-1:0] slot_qid_o,
    output logic [NQ-1:0]     q_valid_o,
    output logic [NQ-1:0]     q_mapped_o,
    output logic [NS-1:0]     fetch_req_o,
    output logic [NS-1:0]     sched_req_o,
    output logic              err_o,
    output logic              warn_o,
    output logic              wake_pending_o
);
    typedef struct packed {
        logic [NQ-1:0]           qv;
        logic [NQ-1:0]           qm;
        logic [NQ-1:0][SW-1:0]   qslot;
        logic [NQ-1:0][WW-1:0]   widx;
        logic [NS-1:0]           sv;
        logic [NS-1:0][QIW-1:0]  sq;
        logic [QIW-1:0]          alp;
        logic [SW-1:0]           rlp;
        logic                    err;
        logic                    warn;
        logic [NS-1:0]           fetch;
        logic [NS-1:0]           sched;
    } st_t;

    st_t s_q, s_d;

    logic           fire, pend, arm;
    logic           acc;
    qs_op_e         op;
    logic [QIW-1:0] qi;
    logic           qid_ok;
    logic [QW-1:0]  db_q;
    logic [QIW-1:0] db_qi;
    logic           db_ok;
    logic           dest_frees;
    logic [NS-1:0]  free_req, idle_req;
    logic [NQ-1:0]  unm_req;
    logic           free_f, idle_f, unm_f;
    logic [SW-1:0]  free_i, idle_i;
    logic [QIW-1:0] unm_i;

    assign cmd_ready = !fire;
    assign acc       = cmd_valid && cmd_ready;

    // command decode and search request vectors
    always_comb begin
        op         = qs_op_e'(cmd_op);
        qi         = cmd_qid[QIW-1:0];
        qid_ok     = cmd_qid < QW'(NQ);
        db_q       = cmd_addr[AW-1:2];
        db_qi      = db_q[QIW-1:0];
        db_ok      = (cmd_addr[1:0] == 2'b00) && (db_q < QW'(NQ)) && s_q.qv[db_qi];
        dest_frees = acc && (op == OP_DESTROY) && qid_ok && s_q.qv[qi] && s_q.qm[qi];
        free_req   = ~s_q.sv;
        if (dest_frees) free_req[s_q.qslot[qi]] = 1'b1;
        idle_req   = s_q.sv & ~slot_dma_busy & ~slot_pkts_busy;
        unm_req    = s_q.qv & ~s_q.qm;
    end

    qs_rr_pick #(.N(NS), .IW(SW)) u_free (
        .req(free_req), .base(s_q.rlp), .found(free_f), .idx(free_i)
    );
    qs_rr_pick #(.N(NS), .IW(SW)) u_idle (
        .req(idle_req), .base(s_q.rlp), .found(idle_f), .idx(idle_i)
    );
    qs_rr_pick #(.N(NQ), .IW(QIW)) u_next (
        .req(unm_req), .base(s_q.alp), .found(unm_f), .idx(unm_i)
    );

    always_comb begin
        logic           map_en;
        logic [QIW-1:0] map_q;
        logic [SW-1:0]  map_s;
        s_d       = s_q;
        s_d.err   = 1'b0;
        s_d.warn  = 1'b0;
        s_d.fetch = '0;
        s_d.sched = '0;
        map_en    = 1'b0;
        map_q     = '0;
        map_s     = '0;

        if (fire) begin
            if (unm_f) begin
                if (free_f) begin
                    map_en = 1'b1;
                    map_q  = unm_i;
                    map_s  = free_i;
                end else if (idle_f) begin
                    s_d.qm[s_q.sq[idle_i]] = 1'b0;
                    map_en = 1'b1;
                    map_q  = unm_i;
                    map_s  = idle_i;
                end
            end
        end else if (acc) begin
            unique case (op)
                OP_CREATE: begin
                    if (!qid_ok || s_q.qv[qi]) begin
                        s_d.err = 1'b1;
                    end else begin
                        s_d.qv[qi]   = 1'b1;
                        s_d.widx[qi] = '0;
                        if (free_f) begin
                            map_en = 1'b1;
                            map_q  = qi;
                            map_s  = free_i;
                        end
                    end
                end
                OP_DESTROY: begin
                    if (!qid_ok || !s_q.qv[qi]) begin
                        s_d.err = 1'b1;
                    end else begin
                        s_d.qv[qi] = 1'b0;
                        s_d.warn   = (cmd_rdidx != s_q.widx[qi]);
                        if (s_q.qm[qi]) begin
                            s_d.qm[qi]              = 1'b0;
                            s_d.sv[s_q.qslot[qi]]   = 1'b0;
                            if (unm_f) begin
                                map_en = 1'b1;
                                map_q  = unm_i;
                                map_s  = free_i;
                            end
                        end
                    end
                end
                OP_DOORBELL: begin
                    if (!db_ok) begin
                        s_d.err = 1'b1;
                    end else begin
                        s_d.widx[db_qi] = cmd_data;
                        if (s_q.qm[db_qi]) s_d.fetch[s_q.qslot[db_qi]] = 1'b1;
                    end
                end
                default: s_d.err = 1'b1;
            endcase
        end

        if (map_en) begin
            s_d.qm[map_q]    = 1'b1;
            s_d.qslot[map_q] = map_s;
            s_d.sv[map_s]    = 1'b1;
            s_d.sq[map_s]    = map_q;
            s_d.alp          = (map_q == QIW'(NQ - 1)) ? '0 : map_q + 1'b1;
            s_d.rlp          = (map_s == SW'(NS - 1)) ? '0 : map_s + 1'b1;
            if (slot_disp_pend[map_s]) begin
                s_d.fetch[map_s] = 1'b1;
                s_d.sched[map_s] = 1'b1;
            end
        end
    end

    assign arm = $countones(s_d.qm) < $countones(s_d.qv);

    qs_wake_timer #(.DW(DW)) u_wake (
        .clk(clk), .rst_n(rst_n), .arm(arm), .delay(wake_delay),
        .fire(fire), .pending(pend)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign slot_valid_o   = s_q.sv;
    assign slot_qid_o     = s_q.sq;
    assign q_valid_o      = s_q.qv;
    assign q_mapped_o     = s_q.qm;
    assign fetch_req_o    = s_q.fetch;
    assign sched_req_o    = s_q.sched;
    assign err_o          = s_q.err;
    assign warn_o         = s_q.warn;
    assign wake_pending_o = pend;
endmodule

// File: rtl/qs_sched_chk.sv
module qs_sched_chk #(
    parameter int NQ  = 8,
    parameter int NS  = 4,
    localparam int QIW = $clog2(NQ)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_ready,
    input logic              wake_pending_o,
    input logic [NS-1:0]     slot_valid_o,
    input logic [NS*QIW-1:0] slot_qid_o,
    input logic [NQ-1:0]     q_valid_o,
    input logic [NQ-1:0]     q_mapped_o,
    input logic [NS-1:0]     fetch_req_o,
    input logic [NS-1:0]     sched_req_o,
    input logic              err_o,
    input logic              warn_o
);
    for (genvar s = 0; s < NS; s++) begin : g_slot
        // R3
        slot_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
            slot_valid_o[s] |-> q_mapped_o[slot_qid_o[s*QIW +: QIW]]);
        for (genvar t = s + 1; t < NS; t++) begin : g_pair
            // R6
            uniq_occ_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !(slot_valid_o[s] && slot_valid_o[t] &&
                  slot_qid_o[s*QIW +: QIW] == slot_qid_o[t*QIW +: QIW]));
        end
    end

    // R6
    cnt_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(slot_valid_o) == $countones(q_mapped_o));
    // R9
    mapped_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_mapped_o & ~q_valid_o) == '0);
    // R12
    fetch_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fetch_req_o));
    // R10
    sched_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sched_req_o & ~fetch_req_o) == '0);
    // R2
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> ($stable(slot_valid_o) && $stable(q_valid_o) && $stable(q_mapped_o)));
    // R5
    fire_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_ready |-> wake_pending_o);
    // R9
    warn_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        warn_o |-> !err_o);
endmodule

bind qslot_sched qs_sched_chk #(.NQ(NQ), .NS(NS)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .wake_pending_o(wake_pending_o),
    .slot_valid_o(slot_valid_o), .slot_qid_o(slot_qid_o), .q_valid_o(q_valid_o),
    .q_mapped_o(q_mapped_o), .fetch_req_o(fetch_req_o), .sched_req_o(sched_req_o),
    .err_o(err_o), .warn_o(warn_o)
);

// File: tb/tb_qslot_sched.sv
`timescale 1ns/1ps
module tb_qslot_sched;
    localparam int NQ = 8;
    localparam int NS = 4;
    localparam int D  = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [1:0]  cmd_op = '0;
    logic [3:0]  cmd_qid = '0;
    logic [5:0]  cmd_addr = '0;
    logic [15:0] cmd_data = '0;
    logic [15:0] cmd_rdidx = '0;
    logic [15:0] wake_delay = 16'(D);
    logic [3:0]  dma = '0, pkts = 4'hF, disp = 4'b0101;
    logic [3:0]  slot_valid_o;
    logic [11:0] slot_qid_o;
    logic [7:0]  q_valid_o, q_mapped_o;
    logic [3:0]  fetch_req_o, sched_req_o;
    logic        err_o, warn_o, wake_pending_o;

    always #2 clk = ~clk;

    qslot_sched dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_qid(cmd_qid), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .cmd_rdidx(cmd_rdidx), .wake_delay(wake_delay), .slot_dma_busy(dma),
        .slot_pkts_busy(pkts), .slot_disp_pend(disp), .slot_valid_o(slot_valid_o),
        .slot_qid_o(slot_qid_o), .q_valid_o(q_valid_o), .q_mapped_o(q_mapped_o),
        .fetch_req_o(fetch_req_o), .sched_req_o(sched_req_o), .err_o(err_o),
        .warn_o(warn_o), .wake_pending_o(wake_pending_o)
    );

    int tests = 0, fails = 0;
    bit run = 0;

    // reference model
    bit m_qv[NQ], m_qm[NQ], m_sv[NS];
    int m_qslot[NQ], m_widx[NQ], m_sq[NS];
    int m_al = 0, m_rl = 0;
    logic [3:0] e_fetch, e_sched;
    bit e_err, e_warn;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int pick_free();
        for (int i = 0; i < NS; i++) if (!m_sv[(m_rl + i) % NS]) return (m_rl + i) % NS;
        return -1;
    endfunction
    function automatic int pick_idle();
        for (int i = 0; i < NS; i++) begin
            int s = (m_rl + i) % NS;
            if (m_sv[s] && !dma[s] && !pkts[s]) return s;
        end
        return -1;
    endfunction
    function automatic int pick_q();
        for (int i = 0; i < NQ; i++) begin
            int q = (m_al + i) % NQ;
            if (m_qv[q] && !m_qm[q]) return q;
        end
        return -1;
    endfunction
    function automatic void m_clear();
        e_fetch = '0; e_sched = '0; e_err = 0; e_warn = 0;
    endfunction
    function automatic void m_map(input int q, input int s);
        m_qm[q] = 1; m_qslot[q] = s; m_sv[s] = 1; m_sq[s] = q;
        m_al = (q + 1) % NQ; m_rl = (s + 1) % NS;
        if (disp[s]) begin e_fetch[s] = 1'b1; e_sched[s] = 1'b1; end
    endfunction
    function automatic void m_wake();
        int q, f, i;
        m_clear();
        q = pick_q();
        if (q >= 0) begin
            f = pick_free();
            if (f >= 0) m_map(q, f);
            else begin
                i = pick_idle();
                if (i >= 0) begin m_qm[m_sq[i]] = 0; m_map(q, i); end
            end
        end
    endfunction
    function automatic void m_cmd(input int op, input int qid, input int addr, input int data, input int rdidx);
        int q, s;
        m_clear();
        case (op)
            0: if (qid >= NQ || m_qv[qid]) e_err = 1;
               else begin
                   m_qv[qid] = 1; m_widx[qid] = 0;
                   s = pick_free();
                   if (s >= 0) m_map(qid, s);
               end
            1: if (qid >= NQ || !m_qv[qid]) e_err = 1;
               else begin
                   m_qv[qid] = 0; e_warn = (rdidx != m_widx[qid]);
                   if (m_qm[qid]) begin
                       m_sv[m_qslot[qid]] = 0; m_qm[qid] = 0;
                       q = pick_q();
                       if (q >= 0) m_map(q, pick_free());
                   end
               end
            2: begin
                   q = addr / 4;
                   if ((addr % 4) != 0 || q >= NQ || !m_qv[q]) e_err = 1;
                   else begin
                       m_widx[q] = data;
                       if (m_qm[q]) e_fetch[m_qslot[q]] = 1'b1;
                   end
               end
            default: e_err = 1;
        endcase
    endfunction

    task automatic check_state(input string req);
        logic [3:0] ev; logic [11:0] eq; logic [7:0] eqv, eqm;
        ev = '0; eq = '0; eqv = '0; eqm = '0;
        for (int s = 0; s < NS; s++) begin ev[s] = m_sv[s]; if (m_sv[s]) eq[s*3 +: 3] = 3'(m_sq[s]); end
        for (int q = 0; q < NQ; q++) begin eqv[q] = m_qv[q]; eqm[q] = m_qm[q]; end
        chk(slot_valid_o == ev, req, "slot_valid", int'(slot_valid_o), int'(ev));
        chk((slot_qid_o & {{3{ev[3]}}, {3{ev[2]}}, {3{ev[1]}}, {3{ev[0]}}}) == eq, req, "slot_qid",
            int'(slot_qid_o), int'(eq));
        chk(q_valid_o == eqv, req, "q_valid", int'(q_valid_o), int'(eqv));
        chk(q_mapped_o == eqm, req, "q_mapped", int'(q_mapped_o), int'(eqm));
    endtask

    task automatic check_pulses(input string req);
        chk(err_o == e_err, req, "err", int'(err_o), int'(e_err));
        chk(warn_o == e_warn, req, "warn", int'(warn_o), int'(e_warn));
        chk(fetch_req_o == e_fetch, req, "fetch", int'(fetch_req_o), int'(e_fetch));
        chk(sched_req_o == e_sched, req, "sched", int'(sched_req_o), int'(e_sched));
        chk($countones(fetch_req_o) <= 1, "R12", "fetch onehot", int'(fetch_req_o), 0);
    endtask

    task automatic send(input int op, input int qid, input int addr, input int data,
                        input int rdidx, input string req);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_op = 2'(op); cmd_qid = 4'(qid); cmd_addr = 6'(addr);
        cmd_data = 16'(data); cmd_rdidx = 16'(rdidx); cmd_valid = 1'b1;
        @(posedge clk);
        m_cmd(op, qid, addr, data, rdidx);
        #1;
        cmd_valid = 1'b0;
        check_pulses(req);
        check_state(req);
    endtask

    task automatic set_flags(input logic [3:0] d, input logic [3:0] p);
        @(posedge clk); #1;
        dma = d; pkts = p;
    endtask

    // wakeup observer: a low ready means the switch happens at the coming edge
    always @(negedge clk) begin
        if (run && rst_n && !cmd_ready) begin
            m_wake();
            @(posedge clk); #1;
            check_pulses("R6/R10 wake");
            check_state("R6 R7 wake");
        end
    end

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(slot_valid_o == 0 && q_valid_o == 0 && q_mapped_o == 0, "R1", "state",
            int'({slot_valid_o, q_valid_o, q_mapped_o}), 0);
        chk(fetch_req_o == 0 && sched_req_o == 0 && !err_o && !warn_o, "R1", "pulses",
            int'({fetch_req_o, sched_req_o, err_o, warn_o}), 0);
        chk(cmd_ready && !wake_pending_o, "R1", "ready/pending", int'({cmd_ready, wake_pending_o}), 2);
        run = 1;

        // R2 out-of-range create, R11 reserved op
        for (int q = NQ; q < 16; q++) send(0, q, 0, 0, 0, "R2 range");
        send(3, 0, 0, 0, 0, "R11");

        // R3 fill slots, R4 overflow with R5 timing on first overflow
        for (int q = 0; q < NQ; q++) begin
            send(0, q, 0, 0, 0, q < NS ? "R3" : "R4");
            if (q == NS) begin
                n = 0;
                do begin @(negedge clk); n++; end while (cmd_ready && n < 20);
                chk(n == D + 1, "R5", "fire delay", n, D + 1);
            end
        end
        for (int q = 0; q < NQ; q++) send(0, q, 0, 0, 0, "R2 dup");

        // R7 all busy: let wakeups abandon
        repeat (12) @(posedge clk);
        @(negedge clk); check_state("R7");

        // R6 evictions through the packet flag, then the DMA flag
        set_flags(4'b0000, 4'b1011);
        repeat (40) @(posedge clk);
        set_flags(4'b1111, 4'b0000);
        repeat (12) @(posedge clk);
        set_flags(4'b1110, 4'b0000);
        repeat (30) @(posedge clk);
        set_flags(4'b0000, 4'b1111);
        repeat (8) @(posedge clk);

        // R8 doorbell sweep over every offset
        for (int a = 0; a < 64; a++) send(2, 0, a, (a * 37 + 5) & 16'hFFFF, 0, "R8");

        // R9 destroy: unknown, then each queue, mismatched read index on odd ones
        send(1, 12, 0, 0, 0, "R9 range");
        for (int q = 0; q < NQ; q++) send(1, q, 0, 0, (q % 2) ? m_widx[q] + 1 : m_widx[q], "R9");
        send(1, 0, 0, 0, 0, "R9 gone");
        send(2, 0, 8, 1, 0, "R8 gone");

        repeat (D + 4) @(posedge clk);
        @(negedge clk);
        chk(!wake_pending_o, "R5", "idle pending", int'(wake_pending_o), 0);
        check_state("R9 final");
        run = 0;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule